// File: doc/BRIEF.md
# Interrupt Option Controller

This block gathers the interrupt requests of a small 8-bit microcontroller and hands the CPU a single pending flag with a vector number. It also drives a wake-up line for the stop and wait low-power modes. Two external request lines come in from the port pins; each pin is already masked by its own port logic. These two lines pass through a synchronizer. Line #1 can be used as a level source or as a rising-edge source. Line #2 latches either rising or falling edges, chosen by a polarity bit. A timer overflow and an end-of-conversion request arrive from on-chip peripherals, each with its own enable. A non-maskable input is latched on its rising edge.

A write-only option byte sits on the data bus at address 0xC8. It holds the line #1 mode, the line #2 polarity and a global enable. The global enable blocks every source except the non-maskable one. While the global enable is low, the non-maskable request is still presented to the CPU but never raises the wake-up line. The CPU clears a latched request by pulsing an acknowledge together with the vector it is serving.

Top module: `irq_opt_ctrl`

## Requirements
- R1: After reset the option byte is 0x00: global enable off, line #1 in edge mode, line #2 on falling edges. irq_pending, irq_vec and wake are all 0.
- R2: The option byte changes only on a clock edge where bus_wr=1, bus_bitop=0 and bus_addr=0xC8. A write with bus_bitop=1, or a write to any other address, leaves the behaviour unchanged.
- R3: bus_rdata is always 0x00; the option byte cannot be read back.
- R4: Option bit 6 set to 1 makes line #1 level sensitive. The request then follows the input, two clocks late, and is never latched. Bit 6 at 0 latches a rising edge three clocks after the input changes. The latch holds until acknowledged with vector 1.
- R5: Option bit 5 picks the line #2 edge: 1 latches rising edges and 0 latches falling edges. The line #2 request is seen three clocks after the edge and holds until acknowledged with vector 2.
- R6: Option bit 4 is the global enable. When it is 0, vectors 1 to 4 never raise irq_pending.
- R7: A rising edge on nmi_in latches a request on vector 0 whatever the global enable is. The request holds until acknowledged with vector 0.
- R8: Vector 3 is requested while tmr_ovf and tmr_en are both 1. Vector 4 is requested while eoc_done and eoc_en are both 1. Both follow their inputs in the same cycle.
- R9: With several requests active, irq_vec shows the lowest-numbered one, so vector 0 ranks first and vector 4 last. irq_vec is 0 when nothing is pending.
- R10: wake is 1 exactly when the global enable is 1 and irq_pending is 1. With the global enable at 0, a pending non-maskable request does not wake the device.
- R11: An acknowledge clears only the latch named by ack_vec. It has no effect on vectors 3 and 4, or on line #1 in level mode. An edge arriving in the same cycle as its own acknowledge keeps the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Data bus address |
| bus_wdata | input | 8 | Data bus write byte |
| bus_wr | input | 1 | Write strobe |
| bus_bitop | input | 1 | Marks the write as a single-bit set or clear |
| bus_rdata | output | 8 | Read data, always zero |
| ext1_in | input | 1 | External request line #1 (port A pins) |
| ext2_in | input | 1 | External request line #2 (port B pins) |
| nmi_in | input | 1 | Non-maskable request input |
| tmr_ovf | input | 1 | Timer overflow flag |
| tmr_en | input | 1 | Timer interrupt enable |
| eoc_done | input | 1 | End-of-conversion flag |
| eoc_en | input | 1 | Conversion interrupt enable |
| ack | input | 1 | CPU acknowledge pulse |
| ack_vec | input | 3 | Vector being acknowledged |
| irq_pending | output | 1 | A request is presented to the CPU |
| irq_vec | output | 3 | Vector of the presented request |
| wake | output | 1 | Wake-up request for stop and wait modes |

## Verification
The properties assume that ack_vec stays in the range 0 to 4 whenever ack is high. They also assume that at most one bus write happens per clock. The random stimulus draws ack_vec only from that range. It usually acknowledges the vector on display, and sometimes a different one, so that the R11 clearing rules are also exercised. Port and non-maskable inputs are held for whole clock periods and change at the falling edge, so the synchronizer sees clean values. The bench model relies on that to fix the latency of each request.

// File: rtl/irq_opt_pkg.sv
package irq_opt_pkg;
    localparam int VEC_W   = 3;
    localparam int NUM_SRC = 5;

    localparam logic [VEC_W-1:0] VEC_NMI = 3'd0;
    localparam logic [VEC_W-1:0] VEC_PA  = 3'd1;
    localparam logic [VEC_W-1:0] VEC_PB  = 3'd2;
    localparam logic [VEC_W-1:0] VEC_TMR = 3'd3;
    localparam logic [VEC_W-1:0] VEC_EOC = 3'd4;

    // option byte field positions
    localparam int OPT_MODE1_BIT = 6;
    localparam int OPT_POL2_BIT  = 5;
    localparam int OPT_GEN_BIT   = 4;

    typedef struct packed {
        logic mode1_level;
        logic pol2_rise;
        logic gen;
    } opt_cfg_t;
endpackage

// File: rtl/irq_opt_sync.sv
module irq_opt_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("irq_opt_sync: STAGES must be at least 2");
        end
    endgenerate
endmodule

// File: rtl/irq_opt_cond.sv
module irq_opt_cond
    import irq_opt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  opt_cfg_t         cfg,
    input  logic             s_ext1,
    input  logic             s_ext2,
    input  logic             s_nmi,
    input  logic             ack,
    input  logic [VEC_W-1:0] ack_vec,
    output logic             req_ext1,
    output logic             req_ext2,
    output logic             req_nmi
);
    typedef struct packed {
        logic prev1;
        logic prev2;
        logic prevn;
        logic pend1;
        logic pend2;
        logic pendn;
    } cond_t;

    cond_t st_d, st_q;

    logic rise1, edge2, risen;
    logic clr1, clr2, clrn;

    always_comb begin
        rise1 = s_ext1 & ~st_q.prev1;
        edge2 = cfg.pol2_rise ? (s_ext2 & ~st_q.prev2) : (~s_ext2 & st_q.prev2);
        risen = s_nmi & ~st_q.prevn;
        clr1  = ack && (ack_vec == VEC_PA);
        clr2  = ack && (ack_vec == VEC_PB);
        clrn  = ack && (ack_vec == VEC_NMI);

        st_d       = st_q;
        st_d.prev1 = s_ext1;
        st_d.prev2 = s_ext2;
        st_d.prevn = s_nmi;
        st_d.pend1 = cfg.mode1_level ? 1'b0 : (rise1 | (st_q.pend1 & ~clr1));
        st_d.pend2 = edge2 | (st_q.pend2 & ~clr2);
        st_d.pendn = risen | (st_q.pendn & ~clrn);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ext1 = cfg.mode1_level ? s_ext1 : st_q.pend1;
    assign req_ext2 = st_q.pend2;
    assign req_nmi  = st_q.pendn;

    // R4: level mode never leaves a latched line #1 request behind
    a_r4_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.mode1_level |=> !st_q.pend1);

    // R7: a latched non-maskable request survives until its own acknowledge
    a_r7_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pendn && !(ack && ack_vec == VEC_NMI)) |=> st_q.pendn);

    // R11: acknowledging vector 0 with no new edge clears the latch
    a_r11_nmi_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_vec == VEC_NMI && !(s_nmi && !st_q.prevn)) |=> !st_q.pendn);

    // R5: line #2 latch keeps its value without an edge or acknowledge
    a_r5_pend2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend2 && !(ack && ack_vec == VEC_PB)) |=> st_q.pend2);
endmodule

// File: rtl/irq_opt_arb.sv
module irq_opt_arb
    import irq_opt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               gen,
    output logic               irq_pending,
    output logic [VEC_W-1:0]   irq_vec,
    output logic               wake
);
    logic [NUM_SRC-1:0] masked;

    always_comb begin
        masked = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i == int'(VEC_NMI)) masked[i] = req[i];
            else                    masked[i] = req[i] & gen;
        end
    end

    always_comb begin
        irq_vec = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (masked[i]) irq_vec = VEC_W'(i);
        end
    end

    assign irq_pending = |masked;
    assign wake        = gen & irq_pending;

    // R9: the presented vector is active and nothing ranked above it is
    a_r9_priority: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (req[irq_vec] && ((masked & ((NUM_SRC'(1) << irq_vec) - NUM_SRC'(1))) == '0)));
endmodule

// File: rtl/irq_opt_ctrl.sv
module irq_opt_ctrl
    import irq_opt_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter int              DATA_W      = 8,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = 8'hC8,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_bitop,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext1_in,
    input  logic              ext2_in,
    input  logic              nmi_in,
    input  logic              tmr_ovf,
    input  logic              tmr_en,
    input  logic              eoc_done,
    input  logic              eoc_en,
    input  logic              ack,
    input  logic [VEC_W-1:0]  ack_vec,
    output logic              irq_pending,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              wake
);
    localparam int EXT_W = 3;

    typedef struct packed {
        opt_cfg_t cfg;
    } top_t;

    top_t st_d, st_q;
    logic wr_hit;
    logic wdata_unused;

    assign wr_hit       = bus_wr && !bus_bitop && (bus_addr == OPT_ADDR);
    assign wdata_unused = ^bus_wdata;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.cfg.mode1_level = bus_wdata[OPT_MODE1_BIT];
            st_d.cfg.pol2_rise   = bus_wdata[OPT_POL2_BIT];
            st_d.cfg.gen         = bus_wdata[OPT_GEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = '0;

    logic [EXT_W-1:0] raw_in, sync_out;
    assign raw_in = {nmi_in, ext2_in, ext1_in};

    irq_opt_sync #(.WIDTH(EXT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    logic req_ext1, req_ext2, req_nmi;

    irq_opt_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (st_q.cfg),
        .s_ext1  (sync_out[0]),
        .s_ext2  (sync_out[1]),
        .s_nmi   (sync_out[2]),
        .ack     (ack),
        .ack_vec (ack_vec),
        .req_ext1(req_ext1),
        .req_ext2(req_ext2),
        .req_nmi (req_nmi)
    );

    logic [NUM_SRC-1:0] req_all;

    always_comb begin
        req_all          = '0;
        req_all[VEC_NMI] = req_nmi;
        req_all[VEC_PA]  = req_ext1;
        req_all[VEC_PB]  = req_ext2;
        req_all[VEC_TMR] = tmr_ovf & tmr_en;
        req_all[VEC_EOC] = eoc_done & eoc_en;
    end

    irq_opt_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_all),
        .gen        (st_q.cfg.gen),
        .irq_pending(irq_pending),
        .irq_vec    (irq_vec),
        .wake       (wake)
    );

    // R2: the option byte moves only on a full-byte write to its address
    a_r2_opt_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(st_q.cfg));

    // R6: with global enable low only the non-maskable vector is presented
    a_r6_gen_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cfg.gen && irq_pending) |-> (irq_vec == VEC_NMI));

    // R10: wake needs both the global enable and a presented request
    a_r10_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (st_q.cfg.gen && irq_pending));
endmodule

// File: tb/sim_irq_opt_ctrl.sv
`timescale 1ns/1ps
module sim_irq_opt_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_bitop = 1'b0;
    logic [7:0] bus_rdata;
    logic       ext1_in = 1'b0, ext2_in = 1'b0, nmi_in = 1'b0;
    logic       tmr_ovf = 1'b0, tmr_en = 1'b0, eoc_done = 1'b0, eoc_en = 1'b0;
    logic       ack = 1'b0;
    logic [2:0] ack_vec = '0;
    logic       irq_pending, wake;
    logic [2:0] irq_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_opt_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_bitop(bus_bitop), .bus_rdata(bus_rdata),
        .ext1_in(ext1_in), .ext2_in(ext2_in), .nmi_in(nmi_in),
        .tmr_ovf(tmr_ovf), .tmr_en(tmr_en), .eoc_done(eoc_done), .eoc_en(eoc_en),
        .ack(ack), .ack_vec(ack_vec),
        .irq_pending(irq_pending), .irq_vec(irq_vec), .wake(wake)
    );

    // requirement model: option bits, two sync stages, previous sample, latches
    bit m_mode, m_pol, m_gen;
    bit x1a, x1b, x1p, x2a, x2b, x2p, xna, xnb, xnp;
    bit m_p1, m_p2, m_pn;

    function automatic bit [4:0] exp_req();
        bit [4:0] r;
        r[0] = m_pn;
        r[1] = m_mode ? x1b : m_p1;
        r[2] = m_p2;
        r[3] = tmr_ovf & tmr_en;
        r[4] = eoc_done & eoc_en;
        return r;
    endfunction

    function automatic bit [4:0] exp_masked();
        bit [4:0] r = exp_req();
        if (!m_gen) r[4:1] = '0;
        return r;
    endfunction

    function automatic bit exp_pending();
        return |exp_masked();
    endfunction

    function automatic bit [2:0] exp_vec();
        bit [4:0] r = exp_masked();
        for (int i = 0; i < 5; i++) if (r[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic model_update();
        bit r1, e2, rn, np1, np2, npn;
        r1  = x1b & ~x1p;
        e2  = m_pol ? (x2b & ~x2p) : (~x2b & x2p);
        rn  = xnb & ~xnp;
        np1 = m_mode ? 1'b0 : (r1 | (m_p1 & ~(ack && ack_vec == 3'd1)));
        np2 = e2 | (m_p2 & ~(ack && ack_vec == 3'd2));
        npn = rn | (m_pn & ~(ack && ack_vec == 3'd0));
        m_p1 = np1; m_p2 = np2; m_pn = npn;
        x1p = x1b; x1b = x1a; x1a = ext1_in;
        x2p = x2b; x2b = x2a; x2a = ext2_in;
        xnp = xnb; xnb = xna; xna = nmi_in;
        if (bus_wr && !bus_bitop && bus_addr == 8'hC8) begin
            m_mode = bus_wdata[6];
            m_pol  = bus_wdata[5];
            m_gen  = bus_wdata[4];
        end
    endtask

    task automatic check1(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        check1(tag, "R6 irq_pending", int'(irq_pending), int'(exp_pending()));
        check1(tag, "R9 irq_vec", int'(irq_vec), int'(exp_vec()));
        check1(tag, "R10 wake", int'(wake), int'(m_gen & exp_pending()));
        check1(tag, "R3 bus_rdata", int'(bus_rdata), 0);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_all(tag);
        ack    = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic wr_opt(input bit [7:0] a, input bit [7:0] d, input bit bitop, input string tag);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_bitop = bitop;
        step(tag);
    endtask

    task automatic do_ack(input bit [2:0] v, input string tag);
        ack = 1'b1; ack_vec = v;
        step(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check_all("R1");

        // R2: bit operation and wrong address leave option unchanged
        tmr_ovf = 1; tmr_en = 1;
        wr_opt(8'hC8, 8'hFF, 1'b1, "R2");
        wr_opt(8'hC9, 8'hFF, 1'b0, "R2");
        step("R2");
        check1("R2", "pending after ignored writes", int'(irq_pending), 0);
        wr_opt(8'hC8, 8'h10, 1'b0, "R2");
        check1("R2", "vector after full write", int'(irq_vec), 3);

        // R8: enables gate timer and conversion sources
        tmr_en = 0; eoc_done = 1; eoc_en = 0;
        step("R8");
        check1("R8", "no source enabled", int'(irq_pending), 0);
        eoc_en = 1;
        step("R8");
        check1("R8", "conversion vector", int'(irq_vec), 4);
        // R11: acknowledging vector 4 leaves it pending
        do_ack(3'd4, "R11");
        check1("R11", "level source after ack", int'(irq_pending), 1);
        eoc_done = 0;
        step("R8");

        // R4: edge mode latches line #1 three clocks after a rising edge
        ext1_in = 1;
        step("R4"); step("R4");
        check1("R4", "no request yet", int'(irq_pending), 0);
        step("R4");
        check1("R4", "edge latched", int'(irq_vec), 1);
        ext1_in = 0;
        repeat (3) step("R4");
        check1("R4", "latch held after input fell", int'(irq_pending), 1);
        do_ack(3'd1, "R4");
        check1("R4", "cleared by ack", int'(irq_pending), 0);
        // level mode
        wr_opt(8'hC8, 8'h50, 1'b0, "R4");
        ext1_in = 1;
        step("R4"); step("R4");
        check1("R4", "level follows input", int'(irq_pending), 1);
        do_ack(3'd1, "R11");
        check1("R11", "level source ignores ack", int'(irq_pending), 1);
        ext1_in = 0;
        step("R4"); step("R4");
        check1("R4", "level drops with input", int'(irq_pending), 0);

        // R5: falling edge with polarity 0, rising with polarity 1
        wr_opt(8'hC8, 8'h10, 1'b0, "R5");
        ext2_in = 1;
        repeat (4) step("R5");
        check1("R5", "rising ignored with pol 0", int'(irq_pending), 0);
        ext2_in = 0;
        repeat (3) step("R5");
        check1("R5", "falling latched", int'(irq_vec), 2);
        do_ack(3'd2, "R5");
        wr_opt(8'hC8, 8'h30, 1'b0, "R5");
        ext2_in = 1;
        repeat (3) step("R5");
        check1("R5", "rising latched with pol 1", int'(irq_pending), 1);
        do_ack(3'd2, "R5");

        // R7 and R10: non-maskable with global enable off does not wake
        wr_opt(8'hC8, 8'h00, 1'b0, "R7");
        nmi_in = 1;
        step("R7");
        nmi_in = 0;
        step("R7"); step("R7");
        check1("R7", "nmi pending with gen 0", int'(irq_pending), 1);
        check1("R10", "no wake with gen 0", int'(wake), 0);
        // R9: nmi ranks over the timer
        tmr_en = 1;
        wr_opt(8'hC8, 8'h10, 1'b0, "R9");
        check1("R9", "nmi first", int'(irq_vec), 0);
        check1("R10", "wake with gen 1", int'(wake), 1);
        do_ack(3'd0, "R9");
        check1("R9", "timer next", int'(irq_vec), 3);
        tmr_en = 0; tmr_ovf = 0;
        step("R9");
        ext2_in = 0;
        repeat (3) step("R9");

        // random phase
        void'($urandom(32'h1D5EED));
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(7) == 0) ext1_in = ~ext1_in;
            if ($urandom_range(7) == 0) ext2_in = ~ext2_in;
            nmi_in = ($urandom_range(31) == 0);
            if ($urandom_range(5) == 0) tmr_ovf = ~tmr_ovf;
            if ($urandom_range(9) == 0) tmr_en = ~tmr_en;
            if ($urandom_range(5) == 0) eoc_done = ~eoc_done;
            if ($urandom_range(9) == 0) eoc_en = ~eoc_en;
            if ($urandom_range(15) == 0) begin
                bus_wr    = 1'b1;
                bus_addr  = ($urandom_range(2) == 0) ? 8'($urandom) : 8'hC8;
                bus_wdata = 8'($urandom);
                bus_bitop = ($urandom_range(3) == 0);
            end
            if (exp_pending() && $urandom_range(1) == 0) begin
                ack     = 1'b1;
                ack_vec = ($urandom_range(3) == 0) ? 3'($urandom_range(4)) : exp_vec();
            end
            step("R11");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule